// File: doc/BRIEF.md
# Half-Bridge Deadtime and Cross-Conduction Interlock

This block sits between the two command inputs of one half-bridge leg and the two gate outputs of that leg. A three-phase driver uses three copies. Both commands are synchronous logic levels. Each command first passes through a minimum-pulse filter, so that short noise spikes never reach a gate. The two cleaned commands then drive a small arbiter. The arbiter never lets both switches conduct at once. It also enforces a fixed minimum interval with both switches off whenever control passes from one switch to the other.

A commanded gap that is already longer than the minimum off-time is not stretched. When both commands are high together, the switch that is already conducting keeps conducting and the late command is ignored. If both commands rise together while both switches are off, neither switch turns on. A supervisor can pull both gates low at once through a force-off input. Force-off also restarts the off-time interval, so a gate comes back no earlier than one full deadtime after force-off is released.

Top module: `leg_interlock`

## Requirements
- R1: While a gate is on and its own command stays high, a rising or held opposite command has no effect: the gate stays on and the opposite gate stays low.
- R2: `hi_gate_o` and `lo_gate_o` are never high in the same cycle.
- R3: When the high gate turns off at clock edge T and the low command is already waiting, the low gate rises exactly at edge T+DEAD_CYC. Both gates stay low for DEAD_CYC cycles in between.
- R4: The handover from low gate to high gate uses the same DEAD_CYC off-time as the handover in R3.
- R5: An isolated command change appears on its gate exactly FILT_CYC+1 clock edges after the change. This holds also when the opposite gate went off more than DEAD_CYC cycles earlier, so no extra delay is added.
- R6: A command pulse shorter than FILT_CYC cycles never reaches its gate. A pulse of exactly FILT_CYC cycles produces a gate pulse of FILT_CYC cycles. This applies to both inputs.
- R7: If both commands become high in the same cycle while both gates are off, both gates stay off. When one command later drops, the other gate turns on.
- R8: With `force_off_i` high, both gates are low in that same cycle (combinational path). After `force_off_i` falls, a gate whose command is still high returns exactly DEAD_CYC clock edges later.
- R9: Both gates are low during reset. After reset is released, no gate turns on before DEAD_CYC clock edges have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hi_cmd_i | input | 1 | High-side switch command, active high |
| lo_cmd_i | input | 1 | Low-side switch command, active high |
| force_off_i | input | 1 | Supervisor shutdown; forces both gates low |
| hi_gate_o | output | 1 | High-side gate command |
| lo_gate_o | output | 1 | Low-side gate command |

## Verification
A corrupted arbiter state shows up at once as an overlap of the two gates, or as a gate that fails to drop FILT_CYC+1 edges after its command falls. A wrong off-time counter is seen one cycle off at the handover edge. For that reason the handovers are sampled at the exact edge, in both directions. A filter counter that is off by one either lets a FILT_CYC-1 pulse through or swallows a FILT_CYC pulse. The gate pulse width is counted to catch either case. Force-off is checked in the same cycle it is applied, and again at the exact cycle the gate returns after release.

// File: rtl/leg_pkg.sv
package leg_pkg;

  // Conduction state of one half-bridge leg
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_HI  = 2'b01,
    LEG_LO  = 2'b10
  } leg_state_e;

  localparam int unsigned NUM_CMD = 2;
  localparam int unsigned IDX_HI  = 1;
  localparam int unsigned IDX_LO  = 0;

endpackage

// File: rtl/cmd_glitch_filter.sv
module cmd_glitch_filter #(
  parameter int unsigned FILT_CYC = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          clean_q, clean_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differ;

  assign differ = raw_i != clean_q;

  always_comb begin
    clean_d = clean_q;
    cnt_d   = '0;
    if (differ) begin
      if (cnt_q == LAST) begin
        clean_d = raw_i;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clean_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      clean_q <= clean_d;
      cnt_q   <= cnt_d;
    end
  end

  assign clean_o = clean_q;

  // R6: the cleaned level only ever moves toward the value last sampled
  assert_follow_input_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean_q != $past(clean_q)) |-> ($past(raw_i) == clean_q));

  // R6: a single sample that agrees with the cleaned level discards the count
  assert_count_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == clean_q) |=> (cnt_q == '0));

endmodule

// File: rtl/leg_dead_timer.sv
module leg_dead_timer #(
  parameter int unsigned DEAD_CYC = 46
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic ready_o
);
  localparam int unsigned CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = cnt_q != LAST;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign ready_o = cnt_q == LAST;

  // R3: a restart always withholds permission in the following cycle
  assert_restart_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !ready_o);

  // R3: once granted, permission persists until the next restart
  assert_ready_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !restart_i) |=> ready_o);

endmodule

// File: rtl/leg_arbiter.sv
module leg_arbiter
  import leg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_cmd_i,
  input  logic lo_cmd_i,
  input  logic force_i,
  input  logic ready_i,
  output logic restart_o,
  output logic hi_on_o,
  output logic lo_on_o
);
  leg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LEG_OFF: begin
        if (ready_i && hi_cmd_i && !lo_cmd_i) begin
          state_d = LEG_HI;
        end else if (ready_i && lo_cmd_i && !hi_cmd_i) begin
          state_d = LEG_LO;
        end
      end
      LEG_HI: begin
        if (!hi_cmd_i) state_d = LEG_OFF;
      end
      LEG_LO: begin
        if (!lo_cmd_i) state_d = LEG_OFF;
      end
      default: state_d = LEG_OFF;
    endcase
    if (force_i) state_d = LEG_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LEG_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  assign restart_o = force_i || ((state_q != LEG_OFF) && (state_d == LEG_OFF));
  assign hi_on_o   = state_q == LEG_HI;
  assign lo_on_o   = state_q == LEG_LO;

  // R1: a conducting high side keeps conducting while its own command holds
  assert_hi_keeps_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_on_o && hi_cmd_i && !force_i) |=> (hi_on_o && !lo_on_o));

  // R1: same for the low side
  assert_lo_keeps_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_on_o && lo_cmd_i && !force_i) |=> (lo_on_o && !hi_on_o));

  // R7: simultaneous requests from the idle state start nothing
  assert_both_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_on_o && !lo_on_o && hi_cmd_i && lo_cmd_i) |=> (!hi_on_o && !lo_on_o));

  // R3: no switch turns on without permission from the off-time timer
  assert_needs_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_on_o && !lo_on_o && !ready_i) |=> (!hi_on_o && !lo_on_o));

endmodule

// File: rtl/leg_interlock.sv
module leg_interlock
  import leg_pkg::*;
#(
  parameter int unsigned FILT_CYC = 35,
  parameter int unsigned DEAD_CYC = 46
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_cmd_i,
  input  logic lo_cmd_i,
  input  logic force_off_i,
  output logic hi_gate_o,
  output logic lo_gate_o
);
  localparam int unsigned OW = $clog2(DEAD_CYC + 1);
  localparam logic [OW-1:0] OFF_MAX = OW'(DEAD_CYC);

  logic [NUM_CMD-1:0] cmd_raw;
  logic [NUM_CMD-1:0] cmd_clean;
  logic               restart, ready;
  logic               hi_on, lo_on;

  assign cmd_raw[IDX_HI] = hi_cmd_i;
  assign cmd_raw[IDX_LO] = lo_cmd_i;

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_filt
    cmd_glitch_filter #(
      .FILT_CYC(FILT_CYC)
    ) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (cmd_raw[g]),
      .clean_o(cmd_clean[g])
    );
  end

  leg_dead_timer #(
    .DEAD_CYC(DEAD_CYC)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .ready_o  (ready)
  );

  leg_arbiter u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hi_cmd_i (cmd_clean[IDX_HI]),
    .lo_cmd_i (cmd_clean[IDX_LO]),
    .force_i  (force_off_i),
    .ready_i  (ready),
    .restart_o(restart),
    .hi_on_o  (hi_on),
    .lo_on_o  (lo_on)
  );

  assign hi_gate_o = hi_on && !force_off_i;
  assign lo_gate_o = lo_on && !force_off_i;

  // Independent run-length of cycles with both switches off, used only by checks
  logic [OW-1:0] off_run_q, off_run_d;

  always_comb begin
    off_run_d = '0;
    if (!hi_on && !lo_on) begin
      off_run_d = (off_run_q == OFF_MAX) ? off_run_q : off_run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_run_q <= '0;
    end else begin
      off_run_q <= off_run_d;
    end
  end

  // R2: never both gates at once
  assert_no_overlap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hi_gate_o, lo_gate_o}));

  // R3: low side turns on only after the full off interval
  assert_lo_offtime_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_on) |-> (off_run_q == OFF_MAX));

  // R4: high side uses the same off interval
  assert_hi_offtime_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_on) |-> (off_run_q == OFF_MAX));

  // R8: supervisor shutdown wins in the same cycle
  assert_force_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |-> (!hi_gate_o && !lo_gate_o));

endmodule

// File: tb/leg_interlock_bench.sv
module leg_interlock_bench;
  localparam int FILT = 35;
  localparam int DEAD = 46;
  localparam time CLK_PERIOD = 10ns;
  localparam int HOLD = 100;
  localparam int NVEC = 10;

  // vector: {hi_cmd, lo_cmd, force, exp_hi, exp_lo}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b100_10,  // R5 high alone
    5'b110_10,  // R1 low request ignored
    5'b010_01,  // R3 handover to low
    5'b110_01,  // R1 high request ignored
    5'b000_00,  // release
    5'b110_00,  // R7 both from idle
    5'b010_01,  // R7 one drops
    5'b011_00,  // R8 forced
    5'b010_01,  // R8 resumes
    5'b000_00   // release
  };

  logic clk, rst_n, hi_cmd, lo_cmd, force_off, hi_gate, lo_gate;
  int checks, failures, overlaps;
  bit done;

  leg_interlock #(.FILT_CYC(FILT), .DEAD_CYC(DEAD)) u_leg_interlock (
    .clk_i(clk), .rst_ni(rst_n), .hi_cmd_i(hi_cmd), .lo_cmd_i(lo_cmd),
    .force_off_i(force_off), .hi_gate_o(hi_gate), .lo_gate_o(lo_gate)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) if (hi_gate && lo_gate) overlaps++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic h, logic l, logic f);
    hi_cmd = h; lo_cmd = l; force_off = f;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // handover: to_lo selects high->low (R3) or low->high (R4)
  task automatic handover(bit to_lo);
    logic old_g, new_g;
    if (to_lo) drive(1, 0, 0); else drive(0, 1, 0);
    cyc(HOLD);
    if (to_lo) drive(0, 1, 0); else drive(1, 0, 0);
    cyc(FILT);
    old_g = to_lo ? hi_gate : lo_gate;
    check(to_lo ? "R3 old gate before off" : "R4 old gate before off", old_g, 1);
    cyc(1);
    old_g = to_lo ? hi_gate : lo_gate;
    check(to_lo ? "R3 old gate off" : "R4 old gate off", old_g, 0);
    cyc(DEAD - 1);
    new_g = to_lo ? lo_gate : hi_gate;
    check(to_lo ? "R3 new gate still off" : "R4 new gate still off", new_g, 0);
    cyc(1);
    new_g = to_lo ? lo_gate : hi_gate;
    check(to_lo ? "R3 new gate on at deadtime" : "R4 new gate on at deadtime", new_g, 1);
  endtask

  // pulse of given width on one input; count gate-high cycles
  task automatic pulse(bit on_hi, int width, int exp, string req);
    int seen;
    seen = 0;
    drive(0, 0, 0);
    cyc(HOLD);
    if (on_hi) drive(1, 0, 0); else drive(0, 1, 0);
    for (int i = 0; i < width; i++) begin
      cyc(1);
      if (on_hi ? hi_gate : lo_gate) seen++;
    end
    drive(0, 0, 0);
    for (int i = 0; i < 150; i++) begin
      cyc(1);
      if (on_hi ? hi_gate : lo_gate) seen++;
    end
    check(req, seen, exp);
  endtask

  initial begin
    checks = 0; failures = 0; overlaps = 0; done = 1'b0;
    drive(1, 0, 0);
    rst_n = 1'b0;
    cyc(5);
    // R9 reset state
    check("R9 hi low in reset", hi_gate, 0);
    check("R9 lo low in reset", lo_gate, 0);
    rst_n = 1'b1;
    cyc(DEAD - 1);
    check("R9 hi held before deadtime", hi_gate, 0);
    cyc(1);
    check("R9 hi on after deadtime", hi_gate, 1);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][4], VEC[v][3], VEC[v][2]);
      cyc(HOLD);
      check($sformatf("R1/R3/R5/R7/R8 vec%0d hi", v), hi_gate, VEC[v][1]);
      check($sformatf("R1/R3/R5/R7/R8 vec%0d lo", v), lo_gate, VEC[v][0]);
    end

    handover(1'b1);  // R3
    handover(1'b0);  // R4

    // R5 long gap passes with pipeline latency only
    drive(0, 1, 0);
    cyc(HOLD);
    drive(0, 0, 0);
    cyc(HOLD);
    drive(1, 0, 0);
    cyc(FILT);
    check("R5 hi not yet", hi_gate, 0);
    cyc(1);
    check("R5 hi on at latency", hi_gate, 1);

    // R8 force-off
    cyc(HOLD);
    drive(1, 0, 1);
    #1;
    check("R8 same-cycle off", hi_gate, 0);
    cyc(3);
    drive(1, 0, 0);
    cyc(DEAD - 1);
    check("R8 held during restart", hi_gate, 0);
    cyc(1);
    check("R8 returns after deadtime", hi_gate, 1);

    // R6 filter
    pulse(1'b1, FILT - 1, 0, "R6 short hi pulse");
    pulse(1'b0, FILT - 1, 0, "R6 short lo pulse");
    pulse(1'b1, FILT, FILT, "R6 min hi pulse");
    pulse(1'b0, FILT, FILT, "R6 min lo pulse");

    check("R2 overlap cycles", overlaps, 0);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule